// File: doc/BRIEF.md
# Serial EEPROM Slave Model with Timed Page Programming

This block models the slave side of a byte-wide serial EEPROM on an SPI bus. A host selects it by pulling chip select low, clocks in an 8-bit instruction and, for memory accesses, a 16-bit address, all most significant bit first. The block then returns status or array data on the serial output, or collects write data in a page buffer. SPI mode 0 and mode 3 are both accepted. Data in is taken on rising serial clock edges and data out is updated on falling edges.

The serial pins are oversampled by a faster system clock. Releasing chip select after a write with at least one whole data byte starts an internal programming cycle. That cycle copies the buffered bytes into the array and lasts a parameterized number of system clocks. A status bit reports busy for the whole cycle. While the cycle runs, the block ignores everything except the status read. When the cycle ends, the write-enable latch clears and the host must set it again before the next write.

The array depth is set by `MEM_AW`. A full-size instance uses 14 bits, which gives 16K bytes. The default uses 12 bits to keep elaboration small. Address bits above `MEM_AW` are never decoded.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and `miso_oe` is low.
- R2: Instruction 0x06 sets the write-enable latch when idle. Instruction 0x05 returns the status byte, with bit 0 = busy and bit 1 = write-enable latch and all other bits 0. It repeats the current status byte for as long as the host keeps clocking.
- R3: Instruction 0x03 followed by a 16-bit address returns array bytes MSB first, starting at that address. The address advances by one per byte and wraps from the top of the array to location 0.
- R4: Only the low `MEM_AW` address bits select a location (A13..A0 at full size). Higher address bits are ignored.
- R5: A write (0x02) issued while the write-enable latch is clear changes no array byte and starts no programming cycle.
- R6: A write stores data bytes at successive offsets within the 64-byte page of its start address. Past offset 63 the offset wraps to offset 0 of the same page, and a later byte replaces an earlier byte at the same offset. Offsets that receive no byte keep their old contents.
- R7: Programming starts on the rising edge of chip select. From the next clock the busy bit reads 1, and the new data becomes readable only after the cycle.
- R8: The busy bit stays 1 for exactly `WRITE_CYCLES` clocks (at least 64). It then returns to 0 in the same clock as the write-enable latch clears.
- R9: While busy, every instruction other than 0x05 is ignored: a read drives nothing, a write enable does not set the latch, and a write changes nothing.
- R10: `miso_oe` is high only while status or read data is being shifted out. It is low during the instruction and address bytes, and it goes low within two clocks of chip select rising.
- R11: Transactions behave the same whether the serial clock idles low (mode 0) or high (mode 3) when chip select falls.
- R12: A write frame that ends before its first whole data byte starts no programming cycle, and a trailing partial byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; low means the pin is high impedance |

## Verification
A serial clock edge that the bench drives is seen at the next system clock edge. An instruction therefore takes effect one clock after the eighth rising edge, and each output bit is valid one clock after its falling edge. The bench samples `miso` a half serial period after each falling edge, well after the update. The reference model records the clock index of every drive: chip select release, each instruction's last rising edge and each output byte's first falling edge. It predicts busy as true exactly for load clocks in the window (release, release + `WRITE_CYCLES`], so each polled status byte is compared to the cycle. Commands sent during a programming cycle are judged by the same window, using the clock of their eighth rising edge.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    // Active instruction held for the rest of a frame
    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_STAT,
        CMD_READ,
        CMD_PROG
    } cmd_e;

    // Which byte of the frame is being received
    typedef enum logic [1:0] {
        PH_OPCODE  = 2'd0,
        PH_ADDR_HI = 2'd1,
        PH_ADDR_LO = 2'd2,
        PH_DATA    = 2'd3
    } phase_e;

    typedef struct packed {
        logic wel;
        logic busy;
    } status_t;

    function automatic logic [7:0] status_byte(input status_t s);
        return {6'b0, s.wel, s.busy};
    endfunction

    // Status reads pass while busy; everything else needs an idle device
    function automatic cmd_e decode_op(input logic [7:0] op, input status_t s);
        cmd_e c;
        c = CMD_IDLE;
        if (op == OP_RDSR) begin
            c = CMD_STAT;
        end else if (!s.busy) begin
            if (op == OP_READ)                c = CMD_READ;
            else if (op == OP_WRITE && s.wel) c = CMD_PROG;
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_ee_frontend.sv
module spi_ee_frontend
    import spi_ee_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       sck_fall,
    output logic       cs_release,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic [2:0] bit_idx,
    output phase_e     phase
);

    logic       sck_q;
    logic       cs_q;
    logic [6:0] shreg;
    logic       sck_rise;

    assign sck_rise   = !cs_n && sck && !sck_q;
    assign sck_fall   = !cs_n && !sck && sck_q;
    assign cs_release = cs_n && !cs_q;
    assign byte_done  = sck_rise && (bit_idx == 3'd7);
    assign byte_val   = {shreg, mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            shreg   <= '0;
            bit_idx <= '0;
            phase   <= PH_OPCODE;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                bit_idx <= '0;
                phase   <= PH_OPCODE;
            end else if (sck_rise) begin
                shreg   <= {shreg[5:0], mosi};
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7 && phase != PH_DATA)
                    phase <= phase_e'(phase + 2'd1);
            end
        end
    end

    // A bit count can only advance while selected
    assert_count_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> (bit_idx == 3'd0 && phase == PH_OPCODE));

endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [PAGE_AW-1:0] wr_off,
    input  logic [7:0]         wr_data,
    input  logic [PAGE_AW-1:0] rd_off,
    output logic [7:0]         rd_data,
    output logic               rd_valid,
    output logic               any_valid
);

    localparam int SLOTS = 1 << PAGE_AW;

    logic [7:0]       slots [SLOTS];
    logic [SLOTS-1:0] filled;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            filled <= '0;
        end else if (wr_en) begin
            filled[wr_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_off] <= wr_data;
    end

    assign rd_data   = slots[rd_off];
    assign rd_valid  = filled[rd_off];
    assign any_valid = |filled;

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
    import spi_ee_pkg::*;
#(
    parameter int MEM_AW       = 12,
    parameter int PAGE_AW      = 6,
    parameter int WRITE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);

    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int CYC        = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
    localparam int TW         = $clog2(CYC + 1);
    localparam int PW         = MEM_AW - PAGE_AW;

    logic        sck_fall, cs_release, byte_done;
    logic [7:0]  byte_val;
    logic [2:0]  bit_idx;
    phase_e      phase;

    status_t             st;
    cmd_e                cmd;
    logic [7:0]          addr_hi;
    logic [15:0]         full_addr;
    logic [MEM_AW-1:0]   rd_addr;
    logic [PW-1:0]       page;
    logic [PAGE_AW-1:0]  fill_off;
    logic [7:0]          out_sh;
    logic                out_en;
    logic [TW-1:0]       timer;

    logic       buf_we, buf_clr, any_valid, slot_valid;
    logic [7:0] slot_data, arr_rdata;
    logic       arr_we, out_phase, copying;
    logic       unused_hi;

    spi_ee_frontend u_front (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sck        (sck),
        .mosi       (mosi),
        .sck_fall   (sck_fall),
        .cs_release (cs_release),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .bit_idx    (bit_idx),
        .phase      (phase)
    );

    assign full_addr = {addr_hi, byte_val};
    assign unused_hi = ^full_addr[15:MEM_AW];
    assign buf_we    = byte_done && phase == PH_DATA && cmd == CMD_PROG;
    assign buf_clr   = byte_done && phase == PH_OPCODE && decode_op(byte_val, st) == CMD_PROG;
    assign out_phase = (cmd == CMD_STAT && phase != PH_OPCODE) ||
                       (cmd == CMD_READ && phase == PH_DATA);
    assign copying   = st.busy && (int'(timer) < PAGE_BYTES);
    assign arr_we    = copying && slot_valid;

    spi_ee_pagebuf #(.PAGE_AW(PAGE_AW)) u_pbuf (
        .clk       (clk),
        .rst       (rst),
        .clear     (buf_clr),
        .wr_en     (buf_we),
        .wr_off    (fill_off),
        .wr_data   (byte_val),
        .rd_off    (timer[PAGE_AW-1:0]),
        .rd_data   (slot_data),
        .rd_valid  (slot_valid),
        .any_valid (any_valid)
    );

    spi_ee_array #(.AW(MEM_AW)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr ({page, timer[PAGE_AW-1:0]}),
        .wdata (slot_data),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            cmd      <= CMD_IDLE;
            addr_hi  <= '0;
            rd_addr  <= '0;
            page     <= '0;
            fill_off <= '0;
            out_sh   <= '0;
            out_en   <= 1'b0;
            timer    <= '0;
        end else begin
            // Programming cycle: copy slots first, then wait out the timer
            if (st.busy) begin
                timer <= timer + 1'b1;
                if (int'(timer) == CYC - 1) begin
                    st.busy <= 1'b0;
                    st.wel  <= 1'b0;
                end
            end

            if (byte_done) begin
                unique case (phase)
                    PH_OPCODE: begin
                        cmd <= decode_op(byte_val, st);
                        if (byte_val == OP_WREN && !st.busy) st.wel <= 1'b1;
                    end
                    PH_ADDR_HI: addr_hi <= byte_val;
                    PH_ADDR_LO: begin
                        rd_addr  <= full_addr[MEM_AW-1:0];
                        page     <= full_addr[MEM_AW-1:PAGE_AW];
                        fill_off <= full_addr[PAGE_AW-1:0];
                    end
                    PH_DATA: if (cmd == CMD_PROG) fill_off <= fill_off + 1'b1;
                endcase
            end

            if (sck_fall && out_phase) begin
                if (bit_idx == 3'd0) begin
                    out_sh <= (cmd == CMD_STAT) ? status_byte(st) : arr_rdata;
                    out_en <= 1'b1;
                    if (cmd == CMD_READ) rd_addr <= rd_addr + 1'b1;
                end else begin
                    out_sh <= {out_sh[6:0], 1'b0};
                end
            end

            if (cs_n) begin
                cmd    <= CMD_IDLE;
                out_en <= 1'b0;
            end

            if (cs_release && cmd == CMD_PROG && any_valid && !st.busy) begin
                st.busy <= 1'b1;
                timer   <= '0;
            end
        end
    end

    assign miso    = out_sh[7];
    assign miso_oe = out_en;

    assert_oe_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !miso_oe);

    assert_oe_only_output_R10: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> (cmd == CMD_STAT || cmd == CMD_READ));

    assert_start_on_release_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(st.busy) |-> $past(cs_n));

    assert_wel_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(st.busy) |-> !st.wel);

    assert_busy_freezes_wel_R9: assert property (@(posedge clk) disable iff (rst)
        (st.busy && $past(st.busy)) |-> $stable(st.wel));

    assert_fill_needs_wel_R5: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> st.wel);

endmodule

// File: tb/spi_ee_slave_bench.sv
module spi_ee_slave_bench;
    import spi_ee_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int MEM_AW     = 12;
    localparam int DEPTH      = 1 << MEM_AW;
    localparam int WC         = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit mode3 = 1'b0;

    logic [7:0] ref_mem [DEPTH];
    bit m_wel = 1'b0;
    bit wr_active = 1'b0;
    int wr_c = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_ee_slave #(.MEM_AW(MEM_AW), .PAGE_AW(6), .WRITE_CYCLES(WC)) u_spi_ee_slave (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Busy as seen by logic sampling at the clock after drive index t
    function automatic bit m_busy(input int t);
        if (wr_active && t > wr_c + WC) begin
            wr_active = 1'b0;
            m_wel     = 1'b0;
        end
        return wr_active && t > wr_c;
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output bit oe_all, output bit oe_none,
                        output int t_fall, output int t_rise);
        oe_all = 1'b1; oe_none = 1'b1; t_fall = 0; t_rise = 0;
        for (int i = 7; i >= 0; i--) begin
            if (i == 7) t_fall = cyc;
            sck = 1'b0; mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            if (miso_oe !== 1'b1) oe_all = 1'b0;
            if (miso_oe !== 1'b0) oe_none = 1'b0;
            if (i == 0) t_rise = cyc;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic begin_frame;
        sck = mode3;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_frame(output int t_cs);
        if (!mode3) begin
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        t_cs = cyc;
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check(miso_oe === 1'b0, "R10 output released after cs rise", miso_oe, 0);
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_rdsr(input int n, input string tag, output logic [7:0] st);
        logic [7:0] rx, exp; bit a, z; int tf, tr, tc;
        begin_frame;
        xfer(OP_RDSR, rx, a, z, tf, tr);
        check(z, {tag, " R10 oe low in opcode"}, 0, 0);
        st = 8'h00;
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx, a, z, tf, tr);
            exp = {6'b0, 1'b0, 1'b0};
            exp[0] = m_busy(tf);
            exp[1] = m_wel;
            check(a && rx === exp, tag, rx, exp);
            st = rx;
        end
        end_frame(tc);
    endtask

    task automatic do_wren;
        logic [7:0] rx; bit a, z; int tf, tr, tc;
        begin_frame;
        xfer(OP_WREN, rx, a, z, tf, tr);
        if (!m_busy(tr)) m_wel = 1'b1;
        end_frame(tc);
    endtask

    task automatic do_read(input logic [15:0] addr, input int n, input string tag);
        logic [7:0] rx, exp; bit a, z, ign; int tf, tr, tc, base;
        begin_frame;
        xfer(OP_READ, rx, a, z, tf, tr);
        ign = m_busy(tr);
        xfer(addr[15:8], rx, a, z, tf, tr);
        check(z, {tag, " R10 oe low in address"}, 1, 0);
        xfer(addr[7:0], rx, a, z, tf, tr);
        base = int'(addr) % DEPTH;
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx, a, z, tf, tr);
            if (ign) begin
                check(z, {tag, " ignored read drives nothing"}, 1, 0);
            end else begin
                exp = ref_mem[(base + k) % DEPTH];
                check(a && rx === exp, tag, rx, exp);
            end
        end
        end_frame(tc);
    endtask

    task automatic do_write(input logic [15:0] addr, input logic [7:0] dq[$],
                            input int extra_bits);
        logic [7:0] rx; bit a, z, acc; int tf, tr, tc, base, off;
        logic [7:0] pb [64];
        bit pv [64];
        for (int s = 0; s < 64; s++) pv[s] = 1'b0;
        begin_frame;
        xfer(OP_WRITE, rx, a, z, tf, tr);
        acc = !m_busy(tr) && m_wel;
        xfer(addr[15:8], rx, a, z, tf, tr);
        xfer(addr[7:0], rx, a, z, tf, tr);
        off = int'(addr) % 64;
        foreach (dq[k]) begin
            xfer(dq[k], rx, a, z, tf, tr);
            pb[off] = dq[k];
            pv[off] = 1'b1;
            off = (off + 1) % 64;
        end
        for (int i = 0; i < extra_bits; i++) begin
            sck = 1'b0; mosi = i[0];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        end_frame(tc);
        if (acc && dq.size() > 0) begin
            base = (int'(addr) % DEPTH) & ~63;
            for (int s = 0; s < 64; s++) if (pv[s]) ref_mem[base + s] = pb[s];
            wr_active = 1'b1;
            wr_c = tc;
        end
    endtask

    task automatic poll(input string tag);
        logic [7:0] st; int polls;
        polls = 0;
        do_rdsr(1, {tag, " R7 busy after release"}, st);
        check(st[0] === 1'b1, "R7 busy reads 1 right after release", st, 1);
        while (st[0] === 1'b1 && polls < 40) begin
            do_rdsr(1, {tag, " R8 busy window"}, st);
            polls++;
        end
        check(st === 8'h00, "R8 ready and latch cleared", st, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog R8: actual timeout expected completion");
        finish_run;
    end

    initial begin
        logic [7:0] st;
        logic [7:0] dq[$];
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(miso_oe === 1'b0, "R1 oe low after reset", miso_oe, 0);
        do_rdsr(1, "R1 status after reset", st);

        do_wren;
        do_rdsr(3, "R2 status repeats with latch set", st);

        dq = {};
        for (int k = 0; k < 64; k++) dq.push_back(8'(k * 7 + 3));
        do_write(16'h0040, dq, 0);
        poll("R6 full page");
        do_read(16'h0040, 64, "R3 page readback");

        dq = {8'hEE};
        do_write(16'h0040, dq, 0);
        do_rdsr(1, "R5 no cycle without latch", st);
        do_read(16'h0040, 2, "R5 array unchanged");

        do_wren;
        dq = {};
        for (int k = 0; k < 66; k++) dq.push_back(8'(8'hA0 ^ k));
        do_write(16'h007E, dq, 0);
        poll("R6 wrap write");
        do_read(16'h0040, 64, "R6 wrap and overwrite");

        mode3 = 1'b1;
        do_wren;
        dq = {8'hA1, 8'hB2, 8'hC3};
        do_write(16'hC100, dq, 0);
        poll("R11 mode3");
        do_read(16'h0100, 3, "R4 high address bits ignored");
        do_read(16'h4101, 2, "R11 mode3 read with alias");
        mode3 = 1'b0;

        do_wren;
        dq = {8'h11, 8'h22};
        do_write(16'h0200, dq, 0);
        do_read(16'h0040, 4, "R9 read ignored while busy");
        dq = {8'h99, 8'h98};
        do_write(16'h0040, dq, 0);
        do_rdsr(1, "R9 status still served while busy", st);
        poll("R9 after ignored commands");
        do_read(16'h0200, 2, "R7 data visible after cycle");
        do_read(16'h0040, 4, "R9 ignored write left data");

        do_wren;
        dq = {};
        do_write(16'h0080, dq, 4);
        do_rdsr(1, "R12 no cycle for empty write", st);
        check(st === 8'h02, "R12 latch kept, not busy", st, 8'h02);

        dq = {};
        for (int k = 0; k < 64; k++) dq.push_back(8'(8'h30 + k));
        do_write(16'h0FC0, dq, 0);
        poll("R3 top page");
        do_wren;
        dq = {8'h5A, 8'hA5};
        do_write(16'h0000, dq, 0);
        poll("R3 bottom page");
        do_read(16'h0FFE, 4, "R3 read wraps at top of array");

        finish_run;
    end

endmodule